// File: doc/BRIEF.md
# Program Trace Capture Unit

This block records what a CPU does into a 64-entry circular trace memory on the chip. Each entry is 42 bits wide and carries a 2-bit kind tag, an 8-bit info byte, a 16-bit address and a 16-bit data field. A 2-bit mode input picks one of four recording policies:

- **Change-of-flow.** Only branch sources, branch destinations and interrupt vectors are recorded.
- **Change-of-flow with loop compression.** As above, but repeated branch sources are suppressed so that a tight loop cannot flood the memory.
- **Detail.** Every data or register access on the observed bus is recorded with its data, its size and its direction. Recording can be restricted to an address window.
- **Program counter.** The address of every executed opcode is recorded, whatever that opcode is.

Recording happens only while the arm input is high. A debugger drains entries, oldest first, through a read port that shows the current head entry and a pop strobe. The port also gives an occupancy count and a sticky flag that shows the memory has wrapped. Once the memory is full, new entries overwrite the oldest ones.

Top module: `trace_capture`

## Requirements
- R1: After reset, count_o is 0 and wrap_o is 0.
- R2: In mode 0 (change-of-flow), each cof_valid_i event with kind 0 (source), 1 (destination) or 2 (vector) is stored. This includes repeated sources. An event with kind 3, and any bus_* or exec_* activity, stores nothing. An entry is {kind[41:40], info[39:32], addr[31:16], data[15:0]}, and info and data are 0 for change-of-flow entries.
- R3: In mode 1 (loop compression), the address of each stored entry is kept in a shadow register. A source event whose address equals the shadow is dropped.
- R4: In mode 1, destination and vector events are always stored, even when their address repeats or equals the shadow.
- R5: Arm going low, or any change of mode_i, clears the shadow. The first source event after a restart is therefore stored.
- R6: In mode 2 (detail), an access with bus_cyc_i 2 (memory) or 3 (register) is stored as kind 3, with its address and data. Info bit 0 is 1 for a word access and bit 1 is 1 for a write. The other info bits are 0.
- R7: In mode 2, bus_cyc_i 0 (idle) and 1 (opcode fetch) cycles are never stored. Change-of-flow events are not stored either.
- R8: In mode 2 with win_en_i high, only accesses with win_lo_i <= address <= win_hi_i are stored. Both bounds are inclusive.
- R9: In mode 3 (program counter), every exec_valid_i cycle stores exec_pc_i as kind 0, with info and data 0. Repeated values are all stored.
- R10: While arm_i is low, nothing is stored in any mode.
- R11: rd_data_o shows the oldest entry, and rd_en_i removes it. Entries come out in write order. A pop while count_o is 0 does nothing. A pop and a write in the same cycle leave the count unchanged.
- R12: The memory holds 64 entries. Once it is full, each write replaces the oldest entry and count_o stays at 64. wrap_o sets on the write into the last slot and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Recording enable |
| mode_i | input | 2 | 0 change-of-flow, 1 loop compression, 2 detail, 3 program counter |
| win_en_i | input | 1 | Enables the detail address window |
| win_lo_i | input | 16 | Lower window bound, inclusive |
| win_hi_i | input | 16 | Upper window bound, inclusive |
| cof_valid_i | input | 1 | Change-of-flow event present |
| cof_kind_i | input | 2 | 0 source, 1 destination, 2 vector |
| cof_addr_i | input | 16 | Change-of-flow address |
| bus_valid_i | input | 1 | Bus observation valid |
| bus_addr_i | input | 16 | Bus address |
| bus_data_i | input | 16 | Bus data |
| bus_word_i | input | 1 | 1 word access, 0 byte access |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_cyc_i | input | 2 | 0 idle, 1 fetch, 2 memory, 3 register |
| exec_valid_i | input | 1 | An opcode executed this cycle |
| exec_pc_i | input | 16 | Address of that opcode |
| rd_en_i | input | 1 | Pop the head entry |
| rd_data_o | output | 42 | Head entry |
| count_o | output | 7 | Number of stored entries |
| wrap_o | output | 1 | Sticky flag: the write pointer has passed the last slot |

## Verification
An event presented in cycle N is written at the clock edge that ends cycle N. Its entry, the new count_o and the new wrap_o can all be read in cycle N+1. A pop requested in cycle N moves the head at that same edge. The shadow compare is combinational against a register loaded at the edge of the storing event, so a duplicate source in cycle N+1 is already dropped. The bench drives every stimulus on the falling edge and reads outputs on the falling edge after the next rising edge. Each event or pop therefore costs exactly one cycle, and each check reads the state that follows it.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    MODE_COF    = 2'd0,
    MODE_LOOP   = 2'd1,
    MODE_DETAIL = 2'd2,
    MODE_PC     = 2'd3
  } trace_mode_e;

  typedef enum logic [1:0] {
    KIND_SRC = 2'd0,
    KIND_DST = 2'd1,
    KIND_VEC = 2'd2,
    KIND_DET = 2'd3
  } entry_kind_e;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_MEM   = 2'd2,
    CYC_REG   = 2'd3
  } bus_cyc_e;

  localparam int unsigned KIND_W = 2;
  localparam int unsigned INFO_W = 8;

  function automatic logic [INFO_W-1:0] info_byte(input logic word, input logic wr);
    return {{(INFO_W-2){1'b0}}, wr, word};
  endfunction
endpackage

// File: rtl/trace_window.sv
module trace_window #(
  parameter int unsigned AW         = 16,
  parameter bit          HAS_WINDOW = 1'b1
) (
  input  logic          en_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  generate
    if (HAS_WINDOW) begin : g_win
      assign hit_o = !en_i || ((addr_i >= lo_i) && (addr_i <= hi_i));
    end else begin : g_nowin
      logic unused;
      assign unused = en_i ^ (^lo_i) ^ (^hi_i) ^ (^addr_i);
      assign hit_o  = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/trace_shadow.sv
module trace_shadow #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [1:0]    mode_i,
  input  logic          store_i,
  input  logic [AW-1:0] store_addr_i,
  input  logic [AW-1:0] cmp_addr_i,
  output logic          hit_o
);
  logic [1:0]    mode_q;
  logic          vld_q;
  logic [AW-1:0] shadow_q;
  logic          mode_chg;

  assign mode_chg = (mode_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 2'd0;
      vld_q    <= 1'b0;
      shadow_q <= '0;
    end else begin
      mode_q <= mode_i;
      if (!arm_i) begin
        vld_q <= 1'b0;
      end else if (store_i) begin
        vld_q    <= 1'b1;
        shadow_q <= store_addr_i;
      end else if (mode_chg) begin
        vld_q <= 1'b0;
      end
    end
  end

  // a mode switch in this cycle invalidates the compare immediately
  assign hit_o = vld_q && !mode_chg && (cmp_addr_i == shadow_q);

  assert_shadow_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !hit_o);
endmodule

// File: rtl/trace_select.sv
module trace_select
  import trace_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  localparam int unsigned EW = KIND_W + INFO_W + AW + DW
) (
  input  logic          arm_i,
  input  logic [1:0]    mode_i,
  input  logic          cof_valid_i,
  input  logic [1:0]    cof_kind_i,
  input  logic [AW-1:0] cof_addr_i,
  input  logic          shadow_hit_i,
  input  logic          bus_valid_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_word_i,
  input  logic          bus_wr_i,
  input  logic [1:0]    bus_cyc_i,
  input  logic          in_win_i,
  input  logic          exec_valid_i,
  input  logic [AW-1:0] exec_pc_i,
  output logic          we_o,
  output logic [EW-1:0] entry_o
);
  logic [KIND_W-1:0] kind;
  logic [INFO_W-1:0] info;
  logic [AW-1:0]     addr;
  logic [DW-1:0]     data;
  logic              cof_ok;
  logic              bus_ok;

  assign cof_ok = cof_valid_i && (cof_kind_i != KIND_DET);
  assign bus_ok = bus_valid_i && (bus_cyc_i == CYC_MEM || bus_cyc_i == CYC_REG) && in_win_i;

  always_comb begin
    we_o = 1'b0;
    kind = KIND_SRC;
    info = '0;
    addr = '0;
    data = '0;
    if (arm_i) begin
      case (mode_i)
        MODE_COF: begin
          we_o = cof_ok;
          kind = cof_kind_i;
          addr = cof_addr_i;
        end
        MODE_LOOP: begin
          // only sources are subject to compression
          we_o = cof_ok && !((cof_kind_i == KIND_SRC) && shadow_hit_i);
          kind = cof_kind_i;
          addr = cof_addr_i;
        end
        MODE_DETAIL: begin
          we_o = bus_ok;
          kind = KIND_DET;
          info = info_byte(bus_word_i, bus_wr_i);
          addr = bus_addr_i;
          data = bus_data_i;
        end
        default: begin
          we_o = exec_valid_i;
          kind = KIND_SRC;
          addr = exec_pc_i;
        end
      endcase
    end
  end

  assign entry_o = {kind, info, addr, data};
endmodule

// File: rtl/trace_ring.sv
module trace_ring #(
  parameter int unsigned EW    = 42,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [EW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [EW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          wrap_o
);
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          wrap_q;
  logic          full, do_pop, rd_adv;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count_q == CW'(DEPTH));
  assign do_pop = rd_en_i && (count_q != '0);
  // a write into a full ring drops the oldest entry
  assign rd_adv = do_pop || (we_i && full);

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      wrap_q   <= 1'b0;
    end else begin
      if (we_i) begin
        wr_ptr_q <= nxt(wr_ptr_q);
        if (wr_ptr_q == PW'(DEPTH - 1)) wrap_q <= 1'b1;
      end
      if (rd_adv) rd_ptr_q <= nxt(rd_ptr_q);
      if (we_i && !do_pop && !full) count_q <= count_q + 1'b1;
      else if (do_pop && !we_i)     count_q <= count_q - 1'b1;
    end
  end

  assign rdata_o = mem[rd_ptr_q];
  assign count_o = count_q;
  assign wrap_o  = wrap_q;

  assert_count_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_wrap_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |=> wrap_q);
  assert_full_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && full) |=> (count_q == CW'(DEPTH)));
  assert_pop_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && count_q == '0 && !we_i) |=> (count_q == '0));
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64,
  parameter bit          HAS_WINDOW = 1'b1,
  localparam int unsigned EW = KIND_W + INFO_W + AW + DW,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [1:0]    mode_i,
  input  logic          win_en_i,
  input  logic [AW-1:0] win_lo_i,
  input  logic [AW-1:0] win_hi_i,
  input  logic          cof_valid_i,
  input  logic [1:0]    cof_kind_i,
  input  logic [AW-1:0] cof_addr_i,
  input  logic          bus_valid_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_word_i,
  input  logic          bus_wr_i,
  input  logic [1:0]    bus_cyc_i,
  input  logic          exec_valid_i,
  input  logic [AW-1:0] exec_pc_i,
  input  logic          rd_en_i,
  output logic [EW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          wrap_o
);
  logic          in_win;
  logic          shadow_hit;
  logic          mem_we;
  logic [EW-1:0] mem_wdata;

  trace_window #(.AW(AW), .HAS_WINDOW(HAS_WINDOW)) u_window (
    .en_i   (win_en_i),
    .lo_i   (win_lo_i),
    .hi_i   (win_hi_i),
    .addr_i (bus_addr_i),
    .hit_o  (in_win)
  );

  trace_shadow #(.AW(AW)) u_shadow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .mode_i       (mode_i),
    .store_i      (mem_we && (mode_i == MODE_LOOP)),
    .store_addr_i (cof_addr_i),
    .cmp_addr_i   (cof_addr_i),
    .hit_o        (shadow_hit)
  );

  trace_select #(.AW(AW), .DW(DW)) u_select (
    .arm_i        (arm_i),
    .mode_i       (mode_i),
    .cof_valid_i  (cof_valid_i),
    .cof_kind_i   (cof_kind_i),
    .cof_addr_i   (cof_addr_i),
    .shadow_hit_i (shadow_hit),
    .bus_valid_i  (bus_valid_i),
    .bus_addr_i   (bus_addr_i),
    .bus_data_i   (bus_data_i),
    .bus_word_i   (bus_word_i),
    .bus_wr_i     (bus_wr_i),
    .bus_cyc_i    (bus_cyc_i),
    .in_win_i     (in_win),
    .exec_valid_i (exec_valid_i),
    .exec_pc_i    (exec_pc_i),
    .we_o         (mem_we),
    .entry_o      (mem_wdata)
  );

  trace_ring #(.EW(EW), .DEPTH(DEPTH)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .wdata_i (mem_wdata),
    .rd_en_i (rd_en_i),
    .rdata_o (rd_data_o),
    .count_o (count_o),
    .wrap_o  (wrap_o)
  );

  assert_disarm_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |-> !mem_we);
  assert_vec_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && mode_i == MODE_LOOP && cof_valid_i && cof_kind_i == KIND_VEC) |-> mem_we);
  assert_detail_skip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && mode_i == MODE_DETAIL) |-> (bus_cyc_i == CYC_MEM || bus_cyc_i == CYC_REG));
  assert_loop_dup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(arm_i) && arm_i && $past(mode_i) == MODE_LOOP
     && mode_i == MODE_LOOP && $past(mem_we) && $past(cof_kind_i) == KIND_SRC
     && cof_valid_i && cof_kind_i == KIND_SRC && cof_addr_i == $past(cof_addr_i))
    |-> !mem_we);
endmodule

// File: tb/trace_capture_tb.sv
module trace_capture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        win_en_i = 1'b0;
  logic [15:0] win_lo_i = '0, win_hi_i = '0;
  logic        cof_valid_i = 1'b0;
  logic [1:0]  cof_kind_i = '0;
  logic [15:0] cof_addr_i = '0;
  logic        bus_valid_i = 1'b0;
  logic [15:0] bus_addr_i = '0, bus_data_i = '0;
  logic        bus_word_i = 1'b0, bus_wr_i = 1'b0;
  logic [1:0]  bus_cyc_i = '0;
  logic        exec_valid_i = 1'b0;
  logic [15:0] exec_pc_i = '0;
  logic        rd_en_i = 1'b0;
  logic [41:0] rd_data_o;
  logic [6:0]  count_o;
  logic        wrap_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trace_capture dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic cof(input logic [1:0] k, input logic [15:0] a);
    cof_valid_i = 1'b1; cof_kind_i = k; cof_addr_i = a;
    step();
    cof_valid_i = 1'b0;
  endtask

  task automatic bus(input logic [15:0] a, input logic [15:0] d, input logic w,
                     input logic wr, input logic [1:0] cyc);
    bus_valid_i = 1'b1; bus_addr_i = a; bus_data_i = d;
    bus_word_i = w; bus_wr_i = wr; bus_cyc_i = cyc;
    step();
    bus_valid_i = 1'b0;
  endtask

  task automatic exe(input logic [15:0] pc);
    exec_valid_i = 1'b1; exec_pc_i = pc;
    step();
    exec_valid_i = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [1:0] k, input logic [7:0] info,
                           input logic [15:0] a, input logic [15:0] d);
    check(req, rd_data_o, {k, info, a, d});
    rd_en_i = 1'b1;
    step();
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", count_o, 0);
    check("R1 wrap", wrap_o, 0);
  endtask

  task automatic t_cof();
    mode_i = 2'd0;
    cof(2'd0, 16'h1000);
    cof(2'd0, 16'h1000);
    bus(16'h2000, 16'h1111, 1'b1, 1'b0, 2'd2);
    exe(16'h2222);
    cof(2'd1, 16'h1100);
    cof(2'd2, 16'hFFF2);
    cof(2'd3, 16'h3333);
    check("R2 count", count_o, 4);
    pop_check("R2 src", 2'd0, 8'h00, 16'h1000, 16'h0);
    pop_check("R2 src repeat", 2'd0, 8'h00, 16'h1000, 16'h0);
    pop_check("R2 dst", 2'd1, 8'h00, 16'h1100, 16'h0);
    pop_check("R2 vec", 2'd2, 8'h00, 16'hFFF2, 16'h0);
  endtask

  task automatic t_loop();
    mode_i = 2'd1;
    step();
    cof(2'd0, 16'h3000);
    cof(2'd0, 16'h3000);
    cof(2'd0, 16'h3000);
    check("R3 dup dropped", count_o, 1);
    cof(2'd1, 16'h3010);
    cof(2'd1, 16'h3010);
    cof(2'd2, 16'hFFF2);
    cof(2'd2, 16'hFFF2);
    check("R4 dst/vec kept", count_o, 5);
    cof(2'd0, 16'hFFF2);
    check("R3 src equal shadow dropped", count_o, 5);
    cof(2'd0, 16'h3000);
    check("R3 new src stored", count_o, 6);
    pop_check("R3 e0", 2'd0, 8'h00, 16'h3000, 16'h0);
    pop_check("R4 e1", 2'd1, 8'h00, 16'h3010, 16'h0);
    pop_check("R4 e2", 2'd1, 8'h00, 16'h3010, 16'h0);
    pop_check("R4 e3", 2'd2, 8'h00, 16'hFFF2, 16'h0);
    pop_check("R4 e4", 2'd2, 8'h00, 16'hFFF2, 16'h0);
    pop_check("R3 e5", 2'd0, 8'h00, 16'h3000, 16'h0);
  endtask

  task automatic t_restart();
    mode_i = 2'd1;
    cof(2'd0, 16'h4000);
    check("R5 first", count_o, 1);
    arm_i = 1'b0;
    cof(2'd0, 16'h5555);
    check("R10 disarmed", count_o, 1);
    arm_i = 1'b1;
    cof(2'd0, 16'h4000);
    check("R5 after rearm", count_o, 2);
    mode_i = 2'd0;
    step();
    mode_i = 2'd1;
    step();
    cof(2'd0, 16'h4000);
    check("R5 after mode change", count_o, 3);
    cof(2'd0, 16'h4000);
    check("R3 compression resumes", count_o, 3);
    pop_check("R5 e0", 2'd0, 8'h00, 16'h4000, 16'h0);
    pop_check("R5 e1", 2'd0, 8'h00, 16'h4000, 16'h0);
    pop_check("R5 e2", 2'd0, 8'h00, 16'h4000, 16'h0);
  endtask

  task automatic t_detail();
    mode_i = 2'd2;
    win_en_i = 1'b0;
    bus(16'h0100, 16'h00AB, 1'b0, 1'b0, 2'd2);
    bus(16'h0202, 16'h1234, 1'b1, 1'b1, 2'd3);
    bus(16'h0404, 16'h9999, 1'b1, 1'b0, 2'd0);
    bus(16'h0505, 16'h8888, 1'b1, 1'b0, 2'd1);
    cof(2'd2, 16'hFFF2);
    check("R7 idle/fetch/cof skipped", count_o, 2);
    bus(16'h0300, 16'h0055, 1'b0, 1'b1, 2'd2);
    check("R6 count", count_o, 3);
    pop_check("R6 byte read", 2'd3, 8'h00, 16'h0100, 16'h00AB);
    pop_check("R6 word write", 2'd3, 8'h03, 16'h0202, 16'h1234);
    pop_check("R6 byte write", 2'd3, 8'h02, 16'h0300, 16'h0055);
  endtask

  task automatic t_window();
    mode_i = 2'd2;
    win_en_i = 1'b1; win_lo_i = 16'h0200; win_hi_i = 16'h02FF;
    bus(16'h01FF, 16'h0001, 1'b1, 1'b0, 2'd2);
    bus(16'h0200, 16'h0002, 1'b1, 1'b0, 2'd2);
    bus(16'h02FF, 16'h0003, 1'b1, 1'b0, 2'd2);
    bus(16'h0300, 16'h0004, 1'b1, 1'b0, 2'd2);
    check("R8 window count", count_o, 2);
    pop_check("R8 low bound", 2'd3, 8'h01, 16'h0200, 16'h0002);
    pop_check("R8 high bound", 2'd3, 8'h01, 16'h02FF, 16'h0003);
    win_en_i = 1'b0;
  endtask

  task automatic t_pc();
    mode_i = 2'd3;
    exe(16'h8000);
    exe(16'h8002);
    exe(16'h8002);
    bus(16'h0100, 16'h0001, 1'b1, 1'b0, 2'd2);
    cof(2'd0, 16'h7000);
    check("R9 count", count_o, 3);
    pop_check("R9 pc0", 2'd0, 8'h00, 16'h8000, 16'h0);
    pop_check("R9 pc1", 2'd0, 8'h00, 16'h8002, 16'h0);
    pop_check("R9 pc2", 2'd0, 8'h00, 16'h8002, 16'h0);
  endtask

  task automatic t_read();
    mode_i = 2'd3;
    rd_en_i = 1'b1;
    step();
    rd_en_i = 1'b0;
    check("R11 pop empty", count_o, 0);
    exe(16'hA000);
    exec_valid_i = 1'b1; exec_pc_i = 16'hA002; rd_en_i = 1'b1;
    step();
    exec_valid_i = 1'b0; rd_en_i = 1'b0;
    check("R11 write+pop count", count_o, 1);
    pop_check("R11 head after write+pop", 2'd0, 8'h00, 16'hA002, 16'h0);
  endtask

  task automatic t_wrap();
    mode_i = 2'd3;
    check("R12 no wrap yet", wrap_o, 0);
    for (int i = 0; i < 70; i++) exe(16'h9000 + 16'(2 * i));
    check("R12 count saturates", count_o, 64);
    check("R12 wrap set", wrap_o, 1);
    for (int i = 6; i < 70; i++)
      pop_check("R12 overwrite order", 2'd0, 8'h00, 16'h9000 + 16'(2 * i), 16'h0);
    check("R12 drained", count_o, 0);
    check("R12 wrap sticky", wrap_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    arm_i = 1'b1;
    t_cof();
    t_loop();
    t_restart();
    t_detail();
    t_window();
    t_pc();
    t_read();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule